// File: doc/BRIEF.md
# Free-running time base with decrementer

This block keeps two 64-bit up-counting time bases, a primary one and an alternate one, plus a 32-bit down-counting decrementer. All three advance on a one-cycle `tick` enable that is produced outside the block at the chosen time-base rate. A simple 32-bit register port lets the core load or read either half of each time base and the whole decrementer. A `run` input freezes both time bases in place. When it returns high they continue from the values they held, so no count is lost or gained.

The decrementer raises a level interrupt request when its value turns negative. This happens either by counting down through zero or by a software write of a negative value over a non-negative one. After it expires it continues counting from all ones. The request stays set until the core pulses a clear strobe.

Reading the primary or alternate low word also captures the matching high word in a snapshot register, so a 64-bit value can be rebuilt without tearing. When the `RTC_VIEW` parameter is set, a legacy real-time-clock window onto the primary low word is available. This window masks both reads and writes.

Top module: `timebase_decr`

## Requirements
- R1: After a synchronous reset both time bases read 0, the decrementer reads 0xFFFFFFFF, `dec_irq` is low and `reg_rdata` is 0.
- R2: The primary time base adds one on each cycle with `tick` and `run` both high. Writing select 0 (low word) replaces bits 31:0 and keeps bits 63:32. Writing select 1 (high word) replaces bits 63:32 and keeps bits 31:0. A write takes priority over the increment in the same cycle.
- R3: The alternate time base behaves like the primary one through select 2 (low word) and select 3 (high word), and it is loaded independently of the primary one.
- R4: While `run` is low, neither time base changes on `tick`. Once `run` is high again they count on from the held values.
- R5: The decrementer (select 4) subtracts one on each `tick`, whatever the level of `run`. A tick at value 0 loads 0xFFFFFFFF and sets `dec_irq`.
- R6: A write to select 4 with bit 31 set sets `dec_irq` only when the current value has bit 31 clear. A write of any value loads the decrementer.
- R7: `dec_irq` stays high until a cycle with `dec_irq_clr` high clears it. If a new expiry happens in the same cycle as the clear, the expiry wins.
- R8: Reading select 0 copies the primary high word into a snapshot that select 6 returns. Reading select 2 does the same for the alternate time base, and select 7 returns that snapshot.
- R9: With `RTC_VIEW`=1, select 5 reads the primary low word ANDed with 0x3FFFFF80. A write to select 5 loads the primary low word with the write data ANDed with 0x3FFFFF80 and keeps the high word.
- R10: Read data is registered. `reg_rdata` shows the selected value as it stood in the `reg_rd` cycle, one clock later, and holds it until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Advance enable for time bases and decrementer |
| run | input | 1 | Time-base run enable; low freezes both time bases |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_sel | input | 3 | Register select (encodings in R2, R3, R5, R8, R9) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| dec_irq_clr | input | 1 | Clears the decrementer interrupt request |
| dec_irq | output | 1 | Decrementer interrupt request, level |

## Verification
The assertions take for granted that `reg_wr` and `reg_rd` are never high in the same cycle. They also take for granted that `reg_sel` is stable for the one cycle a strobe lasts. The stimulus honours this by issuing each access as a single-cycle strobe with idle cycles between accesses. `tick` and `run` are held steady while register accesses take place, except in the deliberate write-versus-increment and expiry-versus-clear collisions. For those, the reference model applies the stated priority.

// File: rtl/tbd_pkg.sv
package tbd_pkg;
  localparam int WORD_W = 32;
  localparam int SEL_W  = 3;

  typedef enum logic [SEL_W-1:0] {
    SEL_TB_LO   = 3'd0,
    SEL_TB_HI   = 3'd1,
    SEL_ATB_LO  = 3'd2,
    SEL_ATB_HI  = 3'd3,
    SEL_DEC     = 3'd4,
    SEL_RTC     = 3'd5,
    SEL_SNAP    = 3'd6,
    SEL_ASNAP   = 3'd7
  } reg_sel_e;
endpackage

// File: rtl/tbd_timebase.sv
module tbd_timebase #(
  parameter int WORD_W = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                adv,
  input  logic                wr_lo,
  input  logic                wr_hi,
  input  logic [WORD_W-1:0]   wdata,
  input  logic                rd_lo,
  output logic [2*WORD_W-1:0] q,
  output logic [WORD_W-1:0]   snap
);
  localparam int TB_W = 2 * WORD_W;

  logic [TB_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (wr_lo) begin
      cnt <= {cnt[TB_W-1:WORD_W], wdata};
    end else if (wr_hi) begin
      cnt <= {wdata, cnt[WORD_W-1:0]};
    end else if (adv) begin
      cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      snap <= '0;
    end else if (rd_lo) begin
      snap <= cnt[TB_W-1:WORD_W];
    end
  end

  assign q = cnt;
endmodule

// File: rtl/tbd_decr.sv
module tbd_decr #(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              wr,
  input  logic [WORD_W-1:0] wdata,
  input  logic              irq_clr,
  output logic [WORD_W-1:0] q,
  output logic              irq
);
  localparam int SIGN = WORD_W - 1;

  logic [WORD_W-1:0] cnt;
  logic              fire;

  always_comb begin
    if (wr) begin
      fire = wdata[SIGN] && !cnt[SIGN];
    end else if (tick) begin
      fire = (cnt == '0);
    end else begin
      fire = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '1;
    end else if (wr) begin
      cnt <= wdata;
    end else if (tick) begin
      cnt <= cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq <= 1'b0;
    end else if (fire) begin
      irq <= 1'b1;
    end else if (irq_clr) begin
      irq <= 1'b0;
    end
  end

  assign q = cnt;
endmodule

// File: rtl/timebase_decr.sv
module timebase_decr
  import tbd_pkg::*;
#(
  parameter int           RTC_VIEW = 1,
  parameter logic [31:0]  RTC_MASK = 32'h3FFF_FF80
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        tick,
  input  logic        run,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [2:0]  reg_sel,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        dec_irq_clr,
  output logic        dec_irq
);
  localparam int NUM_TB = 2;
  localparam int TB_W   = 2 * WORD_W;

  logic [TB_W-1:0]   tb_val  [NUM_TB];
  logic [WORD_W-1:0] tb_snap [NUM_TB];
  logic [WORD_W-1:0] dec_q;
  logic              rtc_wr;
  logic              adv;

  assign adv = tick && run;

  generate
    if (RTC_VIEW != 0) begin : g_rtc
      assign rtc_wr = reg_wr && (reg_sel == SEL_RTC);
    end else begin : g_nortc
      assign rtc_wr = 1'b0;
    end
  endgenerate

  generate
    for (genvar i = 0; i < NUM_TB; i++) begin : g_tb
      localparam logic [2:0] LO_SEL = 3'(2 * i);
      localparam logic [2:0] HI_SEL = 3'(2 * i + 1);
      logic              wlo;
      logic [WORD_W-1:0] wlo_data;
      if (i == 0) begin : g_prim
        assign wlo      = (reg_wr && reg_sel == LO_SEL) || rtc_wr;
        assign wlo_data = rtc_wr ? (reg_wdata & RTC_MASK) : reg_wdata;
      end else begin : g_sec
        assign wlo      = reg_wr && reg_sel == LO_SEL;
        assign wlo_data = reg_wdata;
      end
      tbd_timebase #(.WORD_W(WORD_W)) u_tb (
        .clk   (clk),
        .rst   (rst),
        .adv   (adv),
        .wr_lo (wlo),
        .wr_hi (reg_wr && reg_sel == HI_SEL),
        .wdata (wlo_data),
        .rd_lo (reg_rd && reg_sel == LO_SEL),
        .q     (tb_val[i]),
        .snap  (tb_snap[i])
      );
    end
  endgenerate

  tbd_decr #(.WORD_W(WORD_W)) u_dec (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick),
    .wr      (reg_wr && reg_sel == SEL_DEC),
    .wdata   (reg_wdata),
    .irq_clr (dec_irq_clr),
    .q       (dec_q),
    .irq     (dec_irq)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_rdata <= '0;
    end else if (reg_rd) begin
      case (reg_sel_e'(reg_sel))
        SEL_TB_LO:  reg_rdata <= tb_val[0][WORD_W-1:0];
        SEL_TB_HI:  reg_rdata <= tb_val[0][TB_W-1:WORD_W];
        SEL_ATB_LO: reg_rdata <= tb_val[1][WORD_W-1:0];
        SEL_ATB_HI: reg_rdata <= tb_val[1][TB_W-1:WORD_W];
        SEL_DEC:    reg_rdata <= dec_q;
        SEL_RTC:    reg_rdata <= (RTC_VIEW != 0) ? (tb_val[0][WORD_W-1:0] & RTC_MASK) : '0;
        SEL_SNAP:   reg_rdata <= tb_snap[0];
        default:    reg_rdata <= tb_snap[1];
      endcase
    end
  end
endmodule

// File: rtl/tbd_checker.sv
module tbd_checker (
  input logic        clk,
  input logic        rst,
  input logic        tick,
  input logic        run,
  input logic        reg_wr,
  input logic [2:0]  reg_sel,
  input logic        dec_irq_clr,
  input logic        dec_irq,
  input logic [63:0] tb0,
  input logic [63:0] tb1,
  input logic [31:0] dec
);
  // R1: reset state
  assert_reset_state_R1: assert property (@(posedge clk)
    rst |=> (dec == 32'hFFFF_FFFF) && !dec_irq && (tb0 == 64'd0) && (tb1 == 64'd0));

  // R2: low-word write leaves the high word alone
  assert_lo_keeps_hi_R2: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_sel == 3'd0) |=> tb0[63:32] == $past(tb0[63:32]));

  // R4: frozen time bases hold when untouched by writes
  assert_freeze_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (!run && !(reg_wr && (reg_sel <= 3'd3 || reg_sel == 3'd5))) |=> ($stable(tb0) && $stable(tb1)));

  // R5: expiry wraps to all ones and raises the request
  assert_dec_wrap_R5: assert property (@(posedge clk) disable iff (rst)
    (tick && !(reg_wr && reg_sel == 3'd4) && dec == 32'd0) |=> (dec_irq && dec == 32'hFFFF_FFFF));

  // R6: the request only rises after a decrementer write or an expiry
  assert_irq_cause_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(dec_irq) |-> ($past(reg_wr && reg_sel == 3'd4) || $past(tick && dec == 32'd0)));

  // R7: request is sticky until cleared
  assert_irq_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    (dec_irq && !dec_irq_clr) |=> dec_irq);
endmodule

bind timebase_decr tbd_checker u_chk (
  .clk         (clk),
  .rst         (rst),
  .tick        (tick),
  .run         (run),
  .reg_wr      (reg_wr),
  .reg_sel     (reg_sel),
  .dec_irq_clr (dec_irq_clr),
  .dec_irq     (dec_irq),
  .tb0         (tb_val[0]),
  .tb1         (tb_val[1]),
  .dec         (dec_q)
);

// File: tb/timebase_decr_test.sv
`timescale 1ns/1ps
module timebase_decr_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0, run = 1'b1;
  logic        reg_wr = 1'b0, reg_rd = 1'b0, dec_irq_clr = 1'b0;
  logic [2:0]  reg_sel = 3'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic [31:0] reg_rdata;
  logic        dec_irq;

  int vectors = 0;
  int fails = 0;
  string cur_req = "R1";
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  timebase_decr uut (
    .clk(clk), .rst(rst), .tick(tick), .run(run),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .dec_irq_clr(dec_irq_clr), .dec_irq(dec_irq)
  );

  // behavioural reference model
  logic [63:0] m_tb [2];
  logic [31:0] m_snap [2];
  logic [31:0] m_dec, m_rdata;
  logic        m_irq;
  localparam logic [31:0] MASK = 32'h3FFF_FF80;

  always @(posedge clk) begin
    if (rst) begin
      m_tb[0] = 0; m_tb[1] = 0; m_snap[0] = 0; m_snap[1] = 0;
      m_dec = 32'hFFFF_FFFF; m_rdata = 0; m_irq = 0;
    end else begin
      bit fire;
      fire = 0;
      if (reg_rd) begin
        case (reg_sel)
          0: begin m_rdata = m_tb[0][31:0]; m_snap[0] = m_tb[0][63:32]; end
          1: m_rdata = m_tb[0][63:32];
          2: begin m_rdata = m_tb[1][31:0]; m_snap[1] = m_tb[1][63:32]; end
          3: m_rdata = m_tb[1][63:32];
          4: m_rdata = m_dec;
          5: m_rdata = m_tb[0][31:0] & MASK;
          6: m_rdata = m_snap[0];
          default: m_rdata = m_snap[1];
        endcase
      end
      for (int i = 0; i < 2; i++) begin
        if (reg_wr && reg_sel == 3'(2*i)) m_tb[i][31:0] = reg_wdata;
        else if (reg_wr && i == 0 && reg_sel == 5) m_tb[i][31:0] = reg_wdata & MASK;
        else if (reg_wr && reg_sel == 3'(2*i+1)) m_tb[i][63:32] = reg_wdata;
        else if (tick && run) m_tb[i] = m_tb[i] + 1;
      end
      if (reg_wr && reg_sel == 4) begin
        fire = reg_wdata[31] && !m_dec[31];
        m_dec = reg_wdata;
      end else if (tick) begin
        fire = (m_dec == 0);
        m_dec = m_dec - 1;
      end
      if (fire) m_irq = 1;
      else if (dec_irq_clr) m_irq = 0;
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (!done && !rst) begin
      vectors++;
      if (reg_rdata !== m_rdata || dec_irq !== m_irq) begin
        fails++;
        $display("FAIL %s model: rdata=%h irq=%b expected rdata=%h irq=%b",
                 cur_req, reg_rdata, dec_irq, m_rdata, m_irq);
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] s, input logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_sel = s; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
  endtask

  task automatic rd(input logic [2:0] s, input string req, input logic [31:0] exp);
    @(negedge clk); reg_rd = 1; reg_sel = s;
    @(negedge clk); reg_rd = 0;
    chk(req, reg_rdata, exp);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin @(negedge clk); tick = 1; end
    @(negedge clk); tick = 0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    #100000;
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset values
    cur_req = "R1";
    chk("R1 irq", {31'd0, dec_irq}, 32'd0);
    chk("R1 rdata", reg_rdata, 32'd0);
    rd(0, "R1 tb lo", 32'd0);
    rd(3, "R1 atb hi", 32'd0);
    rd(4, "R1 dec", 32'hFFFF_FFFF);
    // R2/R3 loads and counting
    cur_req = "R2";
    wr(0, 32'hFFFF_FFFE); wr(1, 32'h0000_0005);
    cur_req = "R3";
    wr(2, 32'h0000_0010); wr(3, 32'h0000_000A);
    rd(1, "R3 primary untouched by alt writes", 32'h0000_0005);
    ticks(3);
    cur_req = "R2";
    rd(0, "R2 lo after carry", 32'h0000_0001);
    rd(1, "R2 hi after carry", 32'h0000_0006);
    cur_req = "R8";
    rd(6, "R8 snapshot primary", 32'h0000_0006);
    cur_req = "R3";
    rd(2, "R3 alt lo", 32'h0000_0013);
    rd(7, "R8 snapshot alt", 32'h0000_000A);
    cur_req = "R5";
    rd(4, "R5 dec after 3 ticks", 32'hFFFF_FFFC);
    // R4 freeze
    cur_req = "R4";
    run = 0;
    ticks(5);
    rd(0, "R4 frozen lo", 32'h0000_0001);
    rd(2, "R4 frozen alt lo", 32'h0000_0013);
    rd(4, "R5 dec runs while frozen", 32'hFFFF_FFF7);
    run = 1;
    ticks(2);
    rd(0, "R4 resume lo", 32'h0000_0003);
    // R2 high write keeps low; write beats increment
    cur_req = "R2";
    wr(1, 32'h1234_5678);
    rd(0, "R2 hi write keeps lo", 32'h0000_0003);
    @(negedge clk); tick = 1; reg_wr = 1; reg_sel = 0; reg_wdata = 32'h0000_0100;
    @(negedge clk); tick = 0; reg_wr = 0;
    rd(0, "R2 write wins over tick", 32'h0000_0100);
    // R5 expiry
    cur_req = "R5";
    wr(4, 32'd2);
    chk("R6 positive write no irq", {31'd0, dec_irq}, 32'd0);
    ticks(3);
    chk("R5 irq on expiry", {31'd0, dec_irq}, 32'd1);
    rd(4, "R5 wrap to all ones", 32'hFFFF_FFFF);
    // R7 sticky and clear
    cur_req = "R7";
    repeat (4) @(negedge clk);
    chk("R7 sticky", {31'd0, dec_irq}, 32'd1);
    @(negedge clk); dec_irq_clr = 1;
    @(negedge clk); dec_irq_clr = 0;
    chk("R7 cleared", {31'd0, dec_irq}, 32'd0);
    // R6 negative write
    cur_req = "R6";
    wr(4, 32'h8000_0000);
    chk("R6 neg over neg no irq", {31'd0, dec_irq}, 32'd0);
    wr(4, 32'd5);
    wr(4, 32'h8000_0000);
    chk("R6 neg over pos irq", {31'd0, dec_irq}, 32'd1);
    // R7 expiry beats clear
    cur_req = "R7";
    @(negedge clk); dec_irq_clr = 1;
    @(negedge clk); dec_irq_clr = 0;
    wr(4, 32'd0);
    @(negedge clk); tick = 1; dec_irq_clr = 1;
    @(negedge clk); tick = 0; dec_irq_clr = 0;
    chk("R7 set wins over clear", {31'd0, dec_irq}, 32'd1);
    // R9 legacy view
    cur_req = "R9";
    wr(1, 32'h0000_00AA);
    wr(5, 32'hFFFF_FFFF);
    rd(0, "R9 masked write", 32'h3FFF_FF80);
    rd(1, "R9 hi kept", 32'h0000_00AA);
    wr(0, 32'hFFFF_FFFF);
    rd(5, "R9 masked read", 32'h3FFF_FF80);
    // R10 read data holds
    cur_req = "R10";
    repeat (3) @(negedge clk);
    chk("R10 rdata holds", reg_rdata, 32'h3FFF_FF80);
    finish_run();
  end
endmodule